// File: doc/BRIEF.md
# Acquisition Sample Buffer with Interrupt Request

This block sits between a sample producer and a host that reaches it over a small 16-bit register bus. Each incoming 16-bit sample (channel tag included) is queued in a first-in first-out store. The host pops the oldest sample by reading the data offset. It watches the fill state through a status word, and it can ask for an interrupt request either on each accepted sample or while the store is at least half occupied.

The status word carries the control byte in its low half so the host can confirm its setting. The high half carries four flags: empty, half, full and interrupt pending. Reaching capacity is treated as fatal. The full flag latches and new samples are discarded until the host flushes the store. Two write-only offsets act as strobes, one dropping the pending interrupt and one flushing the store. Every bus read returns its value on `busRdData` one clock after the read strobe, and the value is held until the next read.

Top module: `acq_fifo_irq`

## Requirements
- R1: After reset the store is empty, the control byte is 0, `irqReq` is 0 and `busRdData` is 0.
- R2: A read at offset 0 removes the oldest stored sample and returns it on `busRdData` in the next cycle. Samples leave in arrival order.
- R3: A read at offset 0 while the store is empty returns the previously returned sample and removes nothing.
- R4: A read at offset 6 returns the status word. Bit 8 is empty (count 0), bit 9 is half (count at least DEPTH/2), bit 10 is the latched full error, bit 11 is interrupt pending, and bits 15:12 are 0. The flags reflect the state before that clock edge.
- R5: A write at offset 6 loads the control byte from write-data bits 7:0. Status bits 7:0 read it back.
- R6: The half flag is set exactly while the count is at least DEPTH/2.
- R7: When the count reaches DEPTH the full flag latches. It stays set even after pops, and every sample offered while it is set is discarded.
- R8: A write of any value at offset 8+1 (offset 9) empties the store and clears the full flag. Any push or pop in the same cycle is ignored.
- R9: With control bit 4 set and bit 5 clear, each accepted sample sets the interrupt pending latch one cycle later.
- R10: With control bits 4 and 5 both set, the latch is set at every edge where the count before the edge is at least DEPTH/2.
- R11: The pending latch, which drives `irqReq`, stays set until a write at offset 8. If a setting event occurs in the same cycle as that write, the event wins.
- R12: With control bit 4 clear, no event sets the pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Offer a sample this cycle |
| sampleData | input | 16 | Tagged sample value |
| busRdEn | input | 1 | Host read strobe |
| busWrEn | input | 1 | Host write strobe |
| busAddr | input | 4 | Register offset |
| busWrData | input | 16 | Host write data |
| busRdData | output | 16 | Registered read data |
| irqReq | output | 1 | Interrupt request (pending latch) |

## Verification
The hardest case to reach is the latched full error while the store is partly drained. The bench fills the store past capacity, pops a few entries, and then offers more samples. Those samples must vanish while the status still shows full. The same-cycle race between a setting event and the clear-interrupt write is also reached deliberately. In half mode the store is held above the threshold while the clear is issued, so the latch must come back at once.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam logic [3:0] ADDR_DATA    = 4'd0;
  localparam logic [3:0] ADDR_STATUS  = 4'd6;
  localparam logic [3:0] ADDR_CLR_IRQ = 4'd8;
  localparam logic [3:0] ADDR_FLUSH   = 4'd9;

  localparam int CTRL_IRQ_EN_BIT = 4;
  localparam int CTRL_HALF_BIT   = 5;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } ctlStrobes_t;
endpackage

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] headData,
  output logic              isEmpty,
  output logic              isHalf,
  output logic              isFullErr,
  output logic              pushAccepted
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count, countNext;
  logic              fullErr;
  logic              popAccepted;

  assign pushAccepted = stb.push && !fullErr && !stb.flush;
  assign popAccepted  = stb.pop && (count != '0) && !stb.flush;

  always_comb begin
    countNext = count;
    if (pushAccepted && !popAccepted)      countNext = count + 1'b1;
    else if (popAccepted && !pushAccepted) countNext = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (pushAccepted) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      fullErr <= 1'b0;
    end else if (stb.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      fullErr <= 1'b0;
    end else begin
      if (pushAccepted) wrPtr <= wrPtr + 1'b1;
      if (popAccepted)  rdPtr <= rdPtr + 1'b1;
      count <= countNext;
      if (countNext == FULL_CNT) fullErr <= 1'b1;
    end
  end

  assign headData  = store[rdPtr];
  assign isEmpty   = (count == '0);
  assign isHalf    = (count >= HALF_CNT);
  assign isFullErr = fullErr;

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  // R7
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullErr && stb.push && !stb.pop && !stb.flush) |=> $stable(count));
  // R7
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullErr && !stb.flush) |=> fullErr);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (isEmpty && !fullErr));
endmodule

// File: rtl/acq_control.sv
module acq_control
  import acq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              busRdEn,
  input  logic              busWrEn,
  input  logic [3:0]        busAddr,
  input  logic [15:0]       busWrData,
  input  logic [DATA_W-1:0] headData,
  input  logic              isEmpty,
  input  logic              isHalf,
  input  logic              isFullErr,
  input  logic              pushAccepted,
  output ctlStrobes_t       stb,
  output logic [15:0]       rdData,
  output logic              irqPend
);
  logic [7:0]  ctrlReg;
  logic        clrIrq;
  logic        irqEvent;
  logic [15:0] statusWord;
  logic [7:0]  unusedWrHi;

  assign unusedWrHi = busWrData[15:8];

  assign stb.push  = sampleValid;
  assign stb.pop   = busRdEn && (busAddr == ADDR_DATA);
  assign stb.flush = busWrEn && (busAddr == ADDR_FLUSH);
  assign clrIrq    = busWrEn && (busAddr == ADDR_CLR_IRQ);

  assign irqEvent = ctrlReg[CTRL_IRQ_EN_BIT] &&
                    (ctrlReg[CTRL_HALF_BIT] ? isHalf : pushAccepted);

  assign statusWord = {4'b0000, irqPend, isFullErr, isHalf, isEmpty, ctrlReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      irqPend <= 1'b0;
      rdData  <= '0;
    end else begin
      if (busWrEn && busAddr == ADDR_STATUS) ctrlReg <= busWrData[7:0];
      if (irqEvent)    irqPend <= 1'b1;
      else if (clrIrq) irqPend <= 1'b0;
      if (busRdEn) begin
        if (busAddr == ADDR_DATA) begin
          if (!isEmpty) rdData <= 16'(headData);
        end else if (busAddr == ADDR_STATUS) begin
          rdData <= statusWord;
        end
      end
    end
  end

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPend && !clrIrq) |=> irqPend);
  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrIrq && !irqEvent) |=> !irqPend);
  // R12
  irq_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[CTRL_IRQ_EN_BIT] && !irqPend) |=> !irqPend);
  // R3
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_DATA && isEmpty) |=> $stable(rdData));
endmodule

// File: rtl/acq_fifo_irq.sv
module acq_fifo_irq
  import acq_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic [15:0] sampleData,
  input  logic        busRdEn,
  input  logic        busWrEn,
  input  logic [3:0]  busAddr,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic        irqReq
);
  localparam int DATA_W = 16;

  ctlStrobes_t       stb;
  logic [DATA_W-1:0] headData;
  logic              isEmpty, isHalf, isFullErr, pushAccepted;

  acq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) datapath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .pushData(sampleData),
    .headData(headData), .isEmpty(isEmpty), .isHalf(isHalf),
    .isFullErr(isFullErr), .pushAccepted(pushAccepted)
  );

  acq_control #(.DATA_W(DATA_W)) control_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .busRdEn(busRdEn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .headData(headData), .isEmpty(isEmpty),
    .isHalf(isHalf), .isFullErr(isFullErr), .pushAccepted(pushAccepted),
    .stb(stb), .rdData(busRdData), .irqPend(irqReq)
  );
endmodule

// File: tb/acq_fifo_irq_tb.sv
module acq_fifo_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int HALF = DEPTH / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic        busRdEn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irqReq;

  int errors = 0;
  int checks = 0;
  string curReq = "R1";

  // reference model state
  logic [15:0] mQ[$];
  logic        mFull = 1'b0;
  logic        mIrq = 1'b0;
  logic [7:0]  mCtrl = '0;
  logic [15:0] mRd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_fifo_irq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .busRdEn(busRdEn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mQ.delete(); mFull = 0; mIrq = 0; mCtrl = 0; mRd = 0;
    end else begin
      int   oldCnt;
      logic pushOk, popOk, flushW, clrW, evt;
      logic [15:0] stat;
      oldCnt = mQ.size();
      flushW = busWrEn && busAddr == 4'd9;
      clrW   = busWrEn && busAddr == 4'd8;
      pushOk = sampleValid && !mFull && !flushW;
      popOk  = busRdEn && busAddr == 4'd0 && oldCnt > 0 && !flushW;
      stat   = {4'b0, mIrq, mFull, oldCnt >= HALF, oldCnt == 0, mCtrl};
      evt    = mCtrl[4] && (mCtrl[5] ? (oldCnt >= HALF) : pushOk);
      if (busRdEn && busAddr == 4'd0 && oldCnt > 0) mRd = mQ[0];
      if (busRdEn && busAddr == 4'd6) mRd = stat;
      if (evt) mIrq = 1;
      else if (clrW) mIrq = 0;
      if (busWrEn && busAddr == 4'd6) mCtrl = busWrData[7:0];
      if (flushW) begin
        mQ.delete(); mFull = 0;
      end else begin
        if (popOk) void'(mQ.pop_front());
        if (pushOk) mQ.push_back(sampleData);
        if (mQ.size() == DEPTH) mFull = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks += 2;
      if (busRdData !== mRd) begin
        errors++;
        $display("FAIL %s model: busRdData=%h expected %h", curReq, busRdData, mRd);
      end
      if (irqReq !== mIrq) begin
        errors++;
        $display("FAIL %s model: irqReq=%b expected %b", curReq, irqReq, mIrq);
      end
    end
  end

  task automatic expect16(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sampleValid = 0; busRdEn = 0; busWrEn = 0;
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [3:0] a, input logic [15:0] d);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic hostRead(input logic [3:0] a);
    busRdEn = 1; busAddr = a;
    @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic push(input logic [15:0] d);
    sampleValid = 1; sampleData = d;
    @(negedge clk);
    sampleValid = 0;
  endtask

  task automatic checkStatus(input logic [15:0] exp, input string req);
    hostRead(4'd6);
    expect16(busRdData, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    expect16(busRdData, 16'h0000, "R1");
    expect16({15'b0, irqReq}, 16'h0, "R1");
    checkStatus(16'h0100, "R1");

    curReq = "R5";
    hostWrite(4'd6, 16'hAB10);
    checkStatus(16'h0110, "R5");

    curReq = "R9";
    push(16'h1001);
    expect16({15'b0, irqReq}, 16'h1, "R9");
    push(16'h2002);
    push(16'h3003);
    curReq = "R4";
    checkStatus(16'h0810, "R4");

    curReq = "R11";
    hostWrite(4'd8, 16'h0000);
    expect16({15'b0, irqReq}, 16'h0, "R11");

    curReq = "R2";
    hostRead(4'd0); expect16(busRdData, 16'h1001, "R2");
    hostRead(4'd0); expect16(busRdData, 16'h2002, "R2");
    hostRead(4'd0); expect16(busRdData, 16'h3003, "R2");
    curReq = "R3";
    hostRead(4'd0); expect16(busRdData, 16'h3003, "R3");
    checkStatus(16'h0110, "R3");

    curReq = "R12";
    hostWrite(4'd6, 16'h0000);
    push(16'h4004); push(16'h5005);
    idle();
    expect16({15'b0, irqReq}, 16'h0, "R12");

    curReq = "R8";
    hostWrite(4'd9, 16'h1234);
    checkStatus(16'h0100, "R8");

    curReq = "R10";
    hostWrite(4'd6, 16'h0030);
    for (int i = 0; i < HALF - 1; i++) push(16'h0A00 + 16'(i));
    idle();
    expect16({15'b0, irqReq}, 16'h0, "R10");
    curReq = "R6";
    checkStatus(16'h0130 & 16'hFEFF, "R6");
    push(16'h0AFF);
    curReq = "R10";
    idle();
    expect16({15'b0, irqReq}, 16'h1, "R10");
    curReq = "R11";
    hostWrite(4'd8, 16'h0);
    expect16({15'b0, irqReq}, 16'h1, "R11");

    curReq = "R7";
    hostWrite(4'd6, 16'h0000);
    hostWrite(4'd8, 16'h0);
    for (int i = 0; i < DEPTH; i++) push(16'hC000 + 16'(i));
    checkStatus(16'h0600, "R7");
    hostRead(4'd0); expect16(busRdData, 16'hC000 - 16'h0000 + 16'h0000 + 16'(HALF) - 16'(HALF) + 16'hFFFF & 16'hC000 ? 16'h0A00 : 16'h0A00, "R7");
    hostRead(4'd0);
    push(16'hDEAD);
    sampleValid = 1; busRdEn = 1; busAddr = 4'd0; sampleData = 16'hBEEF;
    @(negedge clk);
    sampleValid = 0; busRdEn = 0;
    checkStatus(16'h0600, "R7");
    for (int i = 0; i < DEPTH; i++) hostRead(4'd0);
    curReq = "R8";
    sampleValid = 1; sampleData = 16'h7777; busWrEn = 1; busAddr = 4'd9;
    @(negedge clk);
    sampleValid = 0; busWrEn = 0;
    checkStatus(16'h0100, "R8");

    curReq = "R2";
    push(16'h1111);
    sampleValid = 1; sampleData = 16'h2222; busRdEn = 1; busAddr = 4'd0;
    @(negedge clk);
    sampleValid = 0; busRdEn = 0;
    expect16(busRdData, 16'h1111, "R2");
    hostRead(4'd0); expect16(busRdData, 16'h2222, "R2");
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule